// File: doc/BRIEF.md
# Predicated SIMD Map-Reduce Array

This block is the data-parallel engine of a map-reduce accelerator. A row of `NCELL` identical cells forms the map level. Each cell owns lane *i* of every vector register, so its small register file holds the i-th element of all `NREG` vectors. A scalar controller issues one instruction per handshake. Each instruction is one of three kinds:
- an element-wise operation between two vectors,
- an operation between a vector and a scalar broadcast to every cell,
- a reduction that folds one vector into a single value through a pipelined tree.

Vector writes are predicated by a per-cell activity mask. The controller forms the mask from the Boolean vector with nested where / elsewhere / endwhere instructions. Compare instructions fill that Boolean vector one bit per cell. Any element of the register file can be read back through a combinational debug port.

All data is unsigned and `DW` bits wide. Opcodes (5 bits):

| Code | Operation |
|---|---|
| 0 | nop |
| 1 | add |
| 2 | sub |
| 3 | and |
| 4 | or |
| 5 | xor |
| 6 | min |
| 7 | max |
| 8 | compare equal |
| 9 | compare less |
| 10 | compare greater |
| 11 | lane index |
| 12 | where |
| 13 | elsewhere |
| 14 | endwhere |
| 16 | reduce sum |
| 17 | reduce min |
| 18 | reduce max |
| 19 | reduce and |
| 20 | reduce or |

Any other code does nothing.

Top module: `simd_mapreduce`

## Requirements
- R1: After synchronous reset:
  - every register element reads 0,
  - `act_mask` is all ones,
  - `bool_vec` is 0,
  - `pred_err` is 0,
  - `in_ready` is 1,
  - `red_valid` is 0.
- R2: Vector-vector ops write `ra OP rb` into register `rd` of every active cell on the accepting edge:
  - codes 1–5 are add, subtract, and, or and xor, with results modulo 2^DW;
  - codes 6–7 are unsigned minimum and maximum.
- R3: With `in_use_scalar`=1, the second operand of codes 1–10 is `in_scalar` in every cell instead of register `rb`.
- R4: Compare codes 8/9/10 set `bool_vec[i]` to `ra==b`, `ra<b` or `ra>b` (unsigned) in each active cell. In that case the register file is unchanged. `bool_vec` changes only on an accepted compare.
- R5: The mask follows a stack of nested regions:
  - `where` (12) pushes the current mask ANDed with `bool_vec`, and remembers that `bool_vec` as the region condition;
  - `elsewhere` (13) replaces the top entry with the parent mask ANDed with the inverted region condition;
  - `endwhere` (14) pops;
  - an empty stack means all cells are active.
- R6: The stack holds 4 levels. The following set `pred_err`, which stays set until reset, and leave the mask unchanged:
  - a `where` at depth 4;
  - an `elsewhere` at depth 0;
  - an `endwhere` at depth 0.
- R7: Reductions 16–20 fold register `ra` over active cells with sum (mod 2^DW), unsigned min, unsigned max, bitwise AND or bitwise OR. Inactive cells contribute the identity value: 0, all ones, 0, all ones and 0 respectively.
- R8: `red_valid` is a one-cycle pulse carrying `red_data`. It rises on the rising edge log2(NCELL)+1 edges after the edge that accepted the reduction.
- R9: `in_ready` is 0 from the edge after a reduction is accepted until `red_valid` rises. No instruction is accepted in that window.
- R10: Lane index (11) writes the cell number i into register `rd` of each active cell.
- R11: Inactive cells keep their register contents on every vector write.
- R12: `dbg_data` shows, combinationally, register `dbg_reg` of cell `dbg_cell`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction valid |
| in_ready | output | 1 | Instruction can be accepted |
| in_op | input | 5 | Opcode |
| in_rd | input | log2(NREG) | Destination register |
| in_ra | input | log2(NREG) | First source register |
| in_rb | input | log2(NREG) | Second source register |
| in_scalar | input | DW | Broadcast scalar operand |
| in_use_scalar | input | 1 | Use scalar as second operand |
| red_valid | output | 1 | Reduction result pulse |
| red_data | output | DW | Reduction result |
| act_mask | output | NCELL | Current per-cell activity mask |
| bool_vec | output | NCELL | Boolean vector |
| pred_err | output | 1 | Sticky predicate stack error |
| dbg_reg | input | log2(NREG) | Debug register index |
| dbg_cell | input | log2(NCELL) | Debug cell index |
| dbg_data | output | DW | Debug element value |

## Verification
Vector, compare and mask instructions take effect on their accepting edge. The bench therefore checks register elements, `bool_vec`, `act_mask` and `pred_err` at the falling edge that follows the accept. For a reduction, the bench counts rising edges from the accept until `red_valid` is seen. It requires that count to be log2(NCELL)+1, and it requires `in_ready` to be low at every falling edge before then. It also checks that the pulse has dropped one cycle later. Debug reads are combinational and are sampled one time unit after changing the select at a falling edge.

// File: rtl/mr_pkg.sv
`timescale 1ns/1ps
package mr_pkg;

    localparam int OPW = 5;

    typedef enum logic [OPW-1:0] {
        OP_NOP   = 5'd0,
        OP_ADD   = 5'd1,
        OP_SUB   = 5'd2,
        OP_AND   = 5'd3,
        OP_OR    = 5'd4,
        OP_XOR   = 5'd5,
        OP_MIN   = 5'd6,
        OP_MAX   = 5'd7,
        OP_CEQ   = 5'd8,
        OP_CLT   = 5'd9,
        OP_CGT   = 5'd10,
        OP_LIDX  = 5'd11,
        OP_WHERE = 5'd12,
        OP_ELSEW = 5'd13,
        OP_ENDW  = 5'd14,
        OP_RSUM  = 5'd16,
        OP_RMIN  = 5'd17,
        OP_RMAX  = 5'd18,
        OP_RAND  = 5'd19,
        OP_ROR   = 5'd20
    } op_e;

    typedef enum logic [1:0] {
        K_NONE,
        K_VEC,
        K_PRED,
        K_RED
    } kind_e;

    function automatic kind_e op_kind(logic [OPW-1:0] op);
        if (op >= 5'd1 && op <= 5'd11) return K_VEC;
        if (op >= 5'd12 && op <= 5'd14) return K_PRED;
        if (op >= 5'd16 && op <= 5'd20) return K_RED;
        return K_NONE;
    endfunction

    function automatic logic op_is_cmp(logic [OPW-1:0] op);
        return (op == OP_CEQ) || (op == OP_CLT) || (op == OP_CGT);
    endfunction

endpackage

// File: rtl/mr_lane.sv
`timescale 1ns/1ps
module mr_lane
    import mr_pkg::*;
#(
    parameter int DW      = 16,
    parameter int NREG    = 8,
    parameter int CELL_ID = 0,
    localparam int RW     = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          vec_we,
    input  logic          act,
    input  logic [OPW-1:0] op,
    input  logic [RW-1:0] rd,
    input  logic [RW-1:0] ra,
    input  logic [RW-1:0] rb,
    input  logic [DW-1:0] scalar,
    input  logic          use_scalar,
    input  logic [RW-1:0] dbg_reg,
    output logic [DW-1:0] ra_val,
    output logic          bool_bit,
    output logic [DW-1:0] dbg_val
);
    logic [DW-1:0] rf [NREG];
    logic [DW-1:0] opa, opb, res;
    logic          cmp;

    assign opa     = rf[ra];
    assign opb     = use_scalar ? scalar : rf[rb];
    assign ra_val  = opa;
    assign dbg_val = rf[dbg_reg];

    always_comb begin
        res = opa;
        cmp = 1'b0;
        case (op)
            OP_ADD:  res = opa + opb;
            OP_SUB:  res = opa - opb;
            OP_AND:  res = opa & opb;
            OP_OR:   res = opa | opb;
            OP_XOR:  res = opa ^ opb;
            OP_MIN:  res = (opa < opb) ? opa : opb;
            OP_MAX:  res = (opa > opb) ? opa : opb;
            OP_LIDX: res = DW'(CELL_ID);
            OP_CEQ:  cmp = (opa == opb);
            OP_CLT:  cmp = (opa < opb);
            OP_CGT:  cmp = (opa > opb);
            default: res = opa;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int r = 0; r < NREG; r++) rf[r] <= '0;
            bool_bit <= 1'b0;
        end else if (vec_we && act) begin
            if (op_is_cmp(op)) bool_bit <= cmp;
            else               rf[rd]   <= res;
        end
    end
endmodule

// File: rtl/mr_pred_stack.sv
`timescale 1ns/1ps
module mr_pred_stack #(
    parameter int NCELL = 8,
    parameter int DEPTH = 4,
    localparam int SPW  = $clog2(DEPTH + 1),
    localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             do_where,
    input  logic             do_else,
    input  logic             do_endw,
    input  logic [NCELL-1:0] cond,
    output logic [NCELL-1:0] mask,
    output logic             err
);
    logic [NCELL-1:0] lvl_mask [DEPTH];
    logic [NCELL-1:0] lvl_cond [DEPTH];
    logic [SPW-1:0]   sp;
    logic [SPW-1:0]   top_s, par_s;
    logic [IW-1:0]    top_i, par_i, push_i;
    logic [NCELL-1:0] parent;

    assign top_s  = sp - SPW'(1);
    assign par_s  = sp - SPW'(2);
    assign top_i  = top_s[IW-1:0];
    assign par_i  = par_s[IW-1:0];
    assign push_i = sp[IW-1:0];

    assign mask   = (sp == '0) ? '1 : lvl_mask[top_i];
    assign parent = (sp <= SPW'(1)) ? '1 : lvl_mask[par_i];

    always_ff @(posedge clk) begin
        if (rst) begin
            sp  <= '0;
            err <= 1'b0;
            for (int l = 0; l < DEPTH; l++) begin
                lvl_mask[l] <= '1;
                lvl_cond[l] <= '0;
            end
        end else if (do_where) begin
            if (sp == SPW'(DEPTH)) begin
                err <= 1'b1;
            end else begin
                lvl_mask[push_i] <= mask & cond;
                lvl_cond[push_i] <= cond;
                sp <= sp + SPW'(1);
            end
        end else if (do_else) begin
            if (sp == '0) err <= 1'b1;
            else          lvl_mask[top_i] <= parent & ~lvl_cond[top_i];
        end else if (do_endw) begin
            if (sp == '0) err <= 1'b1;
            else          sp  <= top_s;
        end
    end
endmodule

// File: rtl/mr_reduce_tree.sv
`timescale 1ns/1ps
module mr_reduce_tree
    import mr_pkg::*;
#(
    parameter int NCELL = 8,
    parameter int DW    = 16,
    localparam int LOG  = $clog2(NCELL),
    localparam int NN   = 2 * NCELL - 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [OPW-1:0]   start_op,
    input  logic [DW-1:0]    vals [NCELL],
    input  logic [NCELL-1:0] mask,
    output logic             res_valid,
    output logic [DW-1:0]    res,
    output logic             busy
);
    logic [OPW-1:0] rop;
    logic [DW-1:0]  node [NN];
    logic [LOG:0]   vp;
    logic [DW-1:0]  ident;

    function automatic logic [DW-1:0] fold(logic [OPW-1:0] o, logic [DW-1:0] a, logic [DW-1:0] b);
        case (o)
            OP_RSUM: return a + b;
            OP_RMIN: return (a < b) ? a : b;
            OP_RMAX: return (a > b) ? a : b;
            OP_RAND: return a & b;
            default: return a | b;
        endcase
    endfunction

    assign ident = (start_op == OP_RMIN || start_op == OP_RAND) ? '1 : '0;
    assign busy  = |vp;

    always_ff @(posedge clk) begin
        if (start) rop <= start_op;
    end

    for (genvar j = 0; j < NCELL; j++) begin : g_leaf
        always_ff @(posedge clk) begin
            if (start) node[NCELL-1+j] <= mask[j] ? vals[j] : ident;
        end
    end

    for (genvar i = 0; i < NCELL - 1; i++) begin : g_node
        always_ff @(posedge clk) begin
            node[i] <= fold(rop, node[2*i+1], node[2*i+2]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vp        <= '0;
            res_valid <= 1'b0;
        end else begin
            vp        <= {vp[LOG-1:0], start};
            res_valid <= vp[LOG];
        end
        res <= node[0];
    end
endmodule

// File: rtl/simd_mapreduce.sv
`timescale 1ns/1ps
module simd_mapreduce
    import mr_pkg::*;
#(
    parameter int NCELL  = 8,
    parameter int DW     = 16,
    parameter int NREG   = 8,
    parameter int PDEPTH = 4,
    localparam int RW    = $clog2(NREG),
    localparam int CW    = $clog2(NCELL)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [OPW-1:0]   in_op,
    input  logic [RW-1:0]    in_rd,
    input  logic [RW-1:0]    in_ra,
    input  logic [RW-1:0]    in_rb,
    input  logic [DW-1:0]    in_scalar,
    input  logic             in_use_scalar,
    output logic             red_valid,
    output logic [DW-1:0]    red_data,
    output logic [NCELL-1:0] act_mask,
    output logic [NCELL-1:0] bool_vec,
    output logic             pred_err,
    input  logic [RW-1:0]    dbg_reg,
    input  logic [CW-1:0]    dbg_cell,
    output logic [DW-1:0]    dbg_data
);
    logic          accept, busy;
    kind_e         kind;
    logic [DW-1:0] ra_vals  [NCELL];
    logic [DW-1:0] dbg_vals [NCELL];

    assign in_ready = ~busy;
    assign accept   = in_valid & in_ready;
    assign kind     = op_kind(in_op);
    assign dbg_data = dbg_vals[dbg_cell];

    for (genvar c = 0; c < NCELL; c++) begin : g_cell
        mr_lane #(.DW(DW), .NREG(NREG), .CELL_ID(c)) u_lane (
            .clk        (clk),
            .rst        (rst),
            .vec_we     (accept && kind == K_VEC),
            .act        (act_mask[c]),
            .op         (in_op),
            .rd         (in_rd),
            .ra         (in_ra),
            .rb         (in_rb),
            .scalar     (in_scalar),
            .use_scalar (in_use_scalar),
            .dbg_reg    (dbg_reg),
            .ra_val     (ra_vals[c]),
            .bool_bit   (bool_vec[c]),
            .dbg_val    (dbg_vals[c])
        );
    end

    mr_pred_stack #(.NCELL(NCELL), .DEPTH(PDEPTH)) u_pred (
        .clk      (clk),
        .rst      (rst),
        .do_where (accept && in_op == OP_WHERE),
        .do_else  (accept && in_op == OP_ELSEW),
        .do_endw  (accept && in_op == OP_ENDW),
        .cond     (bool_vec),
        .mask     (act_mask),
        .err      (pred_err)
    );

    mr_reduce_tree #(.NCELL(NCELL), .DW(DW)) u_tree (
        .clk       (clk),
        .rst       (rst),
        .start     (accept && kind == K_RED),
        .start_op  (in_op),
        .vals      (ra_vals),
        .mask      (act_mask),
        .res_valid (red_valid),
        .res       (red_data),
        .busy      (busy)
    );
endmodule

// File: rtl/mr_checker.sv
`timescale 1ns/1ps
module mr_checker
    import mr_pkg::*;
#(
    parameter int NCELL = 8,
    localparam int LOG  = $clog2(NCELL)
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             in_ready,
    input logic [OPW-1:0]   in_op,
    input logic             red_valid,
    input logic [NCELL-1:0] act_mask,
    input logic [NCELL-1:0] bool_vec,
    input logic             pred_err
);
    logic       acc;
    logic       pend;
    logic [7:0] cnt;

    assign acc = in_valid && in_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= 1'b0;
            cnt  <= '0;
        end else if (acc && op_kind(in_op) == K_RED) begin
            pend <= 1'b1;
            cnt  <= 8'd1;
        end else if (pend) begin
            if (cnt == 8'(LOG + 2)) pend <= 1'b0;
            else                    cnt  <= cnt + 8'd1;
        end
    end

    // R9
    ready_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (acc && op_kind(in_op) == K_RED) |=> !in_ready);

    // R8
    red_latency_chk: assert property (@(posedge clk) disable iff (rst)
        red_valid |-> (pend && cnt == 8'(LOG + 2)));

    // R8
    red_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        red_valid |=> !red_valid);

    // R6
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        pred_err |=> pred_err);

    // R5
    mask_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(acc && op_kind(in_op) == K_PRED) |=> $stable(act_mask));

    // R4
    bool_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(acc && op_is_cmp(in_op)) |=> $stable(bool_vec));
endmodule

bind simd_mapreduce mr_checker #(.NCELL(NCELL)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_op     (in_op),
    .red_valid (red_valid),
    .act_mask  (act_mask),
    .bool_vec  (bool_vec),
    .pred_err  (pred_err)
);

// File: tb/tb_simd_mapreduce.sv
`timescale 1ns/1ps
module tb_simd_mapreduce;
    localparam int NC = 8, DW = 16, NR = 8, LOG = 3;

    logic clk = 0, rst = 1;
    logic in_valid = 0, in_ready, in_use_scalar = 0;
    logic [4:0] in_op = 0;
    logic [2:0] in_rd = 0, in_ra = 0, in_rb = 0, dbg_reg = 0, dbg_cell = 0;
    logic [DW-1:0] in_scalar = 0, red_data, dbg_data;
    logic red_valid, pred_err;
    logic [NC-1:0] act_mask, bool_vec;

    simd_mapreduce dut (.*);

    always #2 clk = ~clk;

    int tests = 0, fails = 0;
    logic [DW-1:0] mem [NR][NC];
    logic [NC-1:0] m_bool, m_smask [4], m_scond [4];
    int m_sp;
    bit m_err;

    task automatic check(string req, longint act, longint exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [NC-1:0] cur_mask();
        return (m_sp == 0) ? '1 : m_smask[m_sp-1];
    endfunction

    function automatic logic [DW-1:0] m_alu(int op, logic [DW-1:0] a, logic [DW-1:0] b, int c);
        case (op)
            1: return a + b;
            2: return a - b;
            3: return a & b;
            4: return a | b;
            5: return a ^ b;
            6: return (a < b) ? a : b;
            7: return (a > b) ? a : b;
            11: return DW'(c);
            default: return a;
        endcase
    endfunction

    function automatic logic [DW-1:0] m_red(int op, int ra);
        logic [DW-1:0] acc = (op == 17 || op == 19) ? '1 : '0;
        for (int c = 0; c < NC; c++) if (cur_mask()[c]) begin
            case (op)
                16: acc = acc + mem[ra][c];
                17: acc = (mem[ra][c] < acc) ? mem[ra][c] : acc;
                18: acc = (mem[ra][c] > acc) ? mem[ra][c] : acc;
                19: acc = acc & mem[ra][c];
                default: acc = acc | mem[ra][c];
            endcase
        end
        return acc;
    endfunction

    task automatic do_reset();
        @(negedge clk); rst = 1; in_valid = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        for (int r = 0; r < NR; r++) for (int c = 0; c < NC; c++) mem[r][c] = 0;
        m_bool = 0; m_sp = 0; m_err = 0;
    endtask

    task automatic peek(int r, int c, output logic [DW-1:0] v);
        dbg_reg = r[2:0]; dbg_cell = c[2:0]; #1; v = dbg_data;
    endtask

    task automatic check_state(string req, int rd);
        logic [DW-1:0] v;
        check({req, " mask"}, act_mask, cur_mask());
        check({req, " bool"}, bool_vec, m_bool);
        check({req, " err"}, pred_err, m_err);
        for (int c = 0; c < NC; c++) begin
            peek(rd, c, v);
            check({req, " R12 elem"}, v, mem[rd][c]);
        end
    endtask

    // issue one instruction, update the model and check its effect
    task automatic issue(int op, int rd, int ra, int rb, logic [DW-1:0] sc, bit us, string req);
        logic [DW-1:0] exp_red;
        logic [NC-1:0] msk, par;
        int n;
        @(negedge clk);
        in_valid = 1; in_op = op[4:0]; in_rd = rd[2:0]; in_ra = ra[2:0];
        in_rb = rb[2:0]; in_scalar = sc; in_use_scalar = us;
        while (!in_ready) @(negedge clk);
        @(posedge clk); #1 in_valid = 0;
        msk = cur_mask();
        if (op >= 1 && op <= 11) begin
            for (int c = 0; c < NC; c++) if (msk[c]) begin
                logic [DW-1:0] a = mem[ra][c];
                logic [DW-1:0] b = us ? sc : mem[rb][c];
                if (op == 8) m_bool[c] = (a == b);
                else if (op == 9) m_bool[c] = (a < b);
                else if (op == 10) m_bool[c] = (a > b);
                else mem[rd][c] = m_alu(op, a, b, c);
            end
        end else if (op == 12) begin
            if (m_sp == 4) m_err = 1;
            else begin m_smask[m_sp] = msk & m_bool; m_scond[m_sp] = m_bool; m_sp++; end
        end else if (op == 13) begin
            if (m_sp == 0) m_err = 1;
            else begin
                par = (m_sp == 1) ? '1 : m_smask[m_sp-2];
                m_smask[m_sp-1] = par & ~m_scond[m_sp-1];
            end
        end else if (op == 14) begin
            if (m_sp == 0) m_err = 1; else m_sp--;
        end
        if (op >= 16 && op <= 20) begin
            exp_red = m_red(op, ra);
            n = 0;
            for (int k = 1; k <= 10; k++) begin
                @(negedge clk);
                if (red_valid) begin n = k; break; end
                check("R9 ready low in flight", in_ready, 0);
            end
            check({req, " R8 latency edges"}, n - 1, LOG + 1);
            check({req, " R7 value"}, red_data, exp_red);
            @(negedge clk);
            check("R8 pulse width", red_valid, 0);
        end else begin
            @(negedge clk);
            check_state(req, rd);
        end
    endtask

    initial begin
        #800000;
        fails++;
        $display("FAIL watchdog expired actual=hung expected=finish");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [DW-1:0] v;
        void'($urandom(32'h1234_5eed));
        do_reset();
        // R1 reset state
        check("R1 ready", in_ready, 1);
        check("R1 mask", act_mask, 8'hFF);
        check("R1 bool", bool_vec, 0);
        check("R1 err", pred_err, 0);
        check("R1 red_valid", red_valid, 0);
        peek(3, 5, v); check("R1 elem", v, 0);

        // R6 underflow on empty stack
        issue(14, 0, 0, 0, 0, 0, "R6 underflow");
        issue(13, 0, 0, 0, 0, 0, "R6 else empty");
        do_reset();
        check("R1 err cleared", pred_err, 0);

        issue(11, 1, 0, 0, 0, 0, "R10 lane index");
        issue(1, 2, 1, 0, 100, 1, "R3 add scalar");
        issue(2, 3, 1, 2, 0, 0, "R2 sub wrap");
        issue(7, 4, 3, 1, 0, 0, "R2 max");
        issue(5, 5, 2, 1, 0, 0, "R2 xor");
        issue(9, 0, 1, 0, 4, 1, "R4 compare less");
        check("R4 bool lower half", bool_vec, 8'h0F);
        issue(12, 0, 0, 0, 0, 0, "R5 where");
        check("R5 where mask", act_mask, 8'h0F);
        issue(1, 6, 1, 0, 7, 1, "R11 predicated add");
        peek(6, 5, v); check("R11 inactive cell kept", v, 0);
        issue(16, 0, 1, 0, 0, 0, "R7 sum active");
        issue(13, 0, 0, 0, 0, 0, "R5 elsewhere");
        check("R5 else mask", act_mask, 8'hF0);
        issue(17, 0, 1, 0, 0, 0, "R7 min active");
        issue(18, 0, 1, 0, 0, 0, "R7 max active");
        issue(14, 0, 0, 0, 0, 0, "R5 endwhere");
        check("R5 end mask", act_mask, 8'hFF);
        // empty mask: identity values
        issue(10, 0, 1, 0, 100, 1, "R4 compare greater");
        issue(12, 0, 0, 0, 0, 0, "R5 empty where");
        issue(16, 0, 2, 0, 0, 0, "R7 ident sum");
        issue(17, 0, 2, 0, 0, 0, "R7 ident min");
        issue(18, 0, 2, 0, 0, 0, "R7 ident max");
        issue(19, 0, 2, 0, 0, 0, "R7 ident and");
        issue(20, 0, 2, 0, 0, 0, "R7 ident or");
        issue(14, 0, 0, 0, 0, 0, "R5 close");
        // R6 overflow
        issue(8, 0, 0, 0, 0, 1, "R4 compare eq");
        for (int d = 0; d < 4; d++) issue(12, 0, 0, 0, 0, 0, "R5 nest");
        issue(12, 0, 0, 0, 0, 0, "R6 overflow");
        check("R6 overflow flag", pred_err, 1);
        for (int d = 0; d < 4; d++) issue(14, 0, 0, 0, 0, 0, "R5 unnest");

        do_reset();
        issue(11, 0, 0, 0, 0, 0, "R10 seed");
        for (int i = 0; i < 400; i++) begin
            int sel = $urandom_range(0, 19);
            int op = (sel < 15) ? sel : sel + 1;
            issue(op, $urandom_range(0, 7), $urandom_range(0, 7), $urandom_range(0, 7),
                  DW'($urandom), $urandom_range(0, 1), "R2 random");
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule